// File: doc/BRIEF.md
# Synchronous Serial Frame Transceiver

This block moves single characters across one shared, idle-high data line. The timing comes from a serial clock supplied by the far end; no baud generator is used. Each character travels in a fixed 12-bit frame: a low start bit, eight data bits with the least significant bit first, an even parity bit, and two high stop bits. The receiver samples the line on the rising edge of the serial clock. The transmitter updates its output on the falling edge, so the far end always samples a settled level.

Received bytes leave on a valid/ready stream together with a parity flag and a framing flag. A flagged byte is still delivered. The output holds its byte, and both of its flags, for as long as `rx_valid` is high and `rx_ready` is low. A frame that completes while the output is still waiting is thrown away. Bytes to send arrive on a second valid/ready stream. A transfer takes place on a falling edge where both `tx_valid` and `tx_ready` are high. `tx_ready` drops while a frame is on the line, while the receiver is busy, while the turnaround input holds off transmission, and while the port is disabled. The transmitter enables the line driver only for the length of its own frame. At all other times the driver is off and the output rests high.

Top module: `sfx_xcvr`

## Requirements
- R1: A transmitted frame carries one bit per serial clock period, and each bit changes on a falling edge. The bit order is: start bit 0, data bits b0 to b7, even parity (the XOR of the eight data bits), then two stop bits of 1.
- R2: `line_oe` is high for exactly 12 consecutive serial clock periods per frame. Whenever `line_oe` is low, `line_out` is 1.
- R3: `tx_ready` is high only when `enable` is high, `tx_allow` is high, no frame is being sent and the receiver is idle. The byte on `tx_data` is captured on the falling edge where `tx_valid` and `tx_ready` are both high.
- R4: While the receiver is idle, a 0 sampled on a rising edge is taken as a start bit. The next eight rising edges sample b0 to b7, least significant bit first.
- R5: If the sampled parity bit differs from the XOR of the received data bits, `rx_parity_err` is 1 for that byte. The byte is still delivered.
- R6: If either stop bit is sampled as 0, `rx_frame_err` is 1 for that byte. The byte is still delivered.
- R7: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and both flags stay unchanged. A frame that completes during this time is discarded. `rx_valid` goes low one rising edge after it is accepted.
- R8: A start bit sampled on the rising edge just after the second stop bit begins a new frame, so frames can follow each other with no idle gap.
- R9: While `line_oe` is high, the receiver ignores `line_in`, and no byte appears because of line activity during that time.
- R10: With `enable` low, `tx_ready` is 0, a frame in progress is abandoned at the next falling edge (driver off, line high), and a low `line_in` does not start a reception.
- R11: After reset, `line_oe` is 0, `line_out` is 1 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the far end |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable |
| tx_allow | input | 1 | Turnaround permit; transmission may start only while high |
| line_in | input | 1 | Sampled level of the shared data line |
| line_out | output | 1 | Level driven onto the data line |
| line_oe | output | 1 | Driver enable for the data line |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch on the received byte |
| rx_frame_err | output | 1 | A stop bit was low on the received byte |
| rx_valid | output | 1 | Received byte is available |
| rx_ready | input | 1 | Consumer accepts the received byte |

## Verification
The hardest case to reach from the ports is the one where two halves of the block meet. A frame must finish arriving while the previous byte is still held, or the line must show a start pattern while the block is itself driving it. To reach the first, the bench holds `rx_ready` low across two whole back-to-back frames and checks that the first byte survives. To reach the second, it holds `line_in` low for the whole of every transmitted frame during the full 256-value transmit sweep. The receive sweep sends every byte value back to back with no idle gap. Parity and stop-bit faults are then injected across a spread of byte values.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int START_BITS = 1;
  localparam int PARITY_BITS = 1;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_PAR  = 2'd2,
    RX_STOP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sfx_rx.sv
module sfx_rx
  import sfx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hold_off,
  input  logic              line_in,
  output logic              busy,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int CW = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_bad_q;
  logic              stop_bad_q;
  logic              done;
  logic              load;

  assign busy = (state_q != RX_IDLE);
  assign done = enable && (state_q == RX_STOP) && (cnt_q == CW'(STOP_BITS - 1));
  assign load = done && (!out_valid || out_ready);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      par_bad_q  <= 1'b0;
      stop_bad_q <= 1'b0;
    end else if (!enable) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (!hold_off && !line_in) begin
            state_q <= RX_DATA;
            cnt_q   <= '0;
          end
        end
        RX_DATA: begin
          shift_q <= {line_in, shift_q[DATA_W-1:1]};
          if (cnt_q == CW'(DATA_W - 1)) begin
            state_q <= RX_PAR;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          par_bad_q  <= line_in ^ (^shift_q);
          stop_bad_q <= 1'b0;
          state_q    <= RX_STOP;
          cnt_q      <= '0;
        end
        RX_STOP: begin
          stop_bad_q <= stop_bad_q | !line_in;
          if (cnt_q == CW'(STOP_BITS - 1)) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_par_err <= 1'b0;
      out_frm_err <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_data    <= shift_q;
      out_par_err <= par_bad_q;
      out_frm_err <= stop_bad_q | !line_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tx_allow,
  input  logic              rx_busy,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              line_out,
  output logic              line_oe
);
  localparam int FRAME_W = START_BITS + DATA_W + PARITY_BITS + STOP_BITS;
  localparam int CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_vec;
  logic [FRAME_W-1:0] shift_q;
  logic [CW-1:0]      cnt_q;
  logic               busy_q;
  logic               out_q;

  assign frame_vec = {{STOP_BITS{1'b1}}, ^in_data, in_data, 1'b0};
  assign in_ready  = !busy_q && enable && tx_allow && !rx_busy;
  assign line_oe   = busy_q;
  assign line_out  = out_q;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      out_q   <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '1;
    end else if (!enable) begin
      busy_q <= 1'b0;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (in_valid && in_ready) begin
        busy_q  <= 1'b1;
        out_q   <= frame_vec[0];
        shift_q <= {1'b1, frame_vec[FRAME_W-1:1]};
        cnt_q   <= CW'(1);
      end
    end else if (cnt_q == CW'(FRAME_W)) begin
      busy_q <= 1'b0;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      out_q   <= shift_q[0];
      shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfx_xcvr.sv
module sfx_xcvr
  import sfx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tx_allow,
  input  logic              line_in,
  output logic              line_out,
  output logic              line_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_parity_err,
  output logic              rx_frame_err,
  output logic              rx_valid,
  input  logic              rx_ready
);
  logic rx_busy;

  sfx_rx #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_rx (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .enable     (enable),
    .hold_off   (line_oe),
    .line_in    (line_in),
    .busy       (rx_busy),
    .out_data   (rx_data),
    .out_par_err(rx_parity_err),
    .out_frm_err(rx_frame_err),
    .out_valid  (rx_valid),
    .out_ready  (rx_ready)
  );

  sfx_tx #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_tx (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx_allow (tx_allow),
    .rx_busy  (rx_busy),
    .in_data  (tx_data),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .line_out (line_out),
    .line_oe  (line_oe)
  );
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker #(
  parameter int DATA_W = 8,
  parameter int STOP_BITS = 2
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              enable,
  input logic              line_out,
  input logic              line_oe,
  input logic              tx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_parity_err,
  input logic              rx_frame_err,
  input logic              rx_valid,
  input logic              rx_ready
);
  localparam int FRAME_W = 2 + DATA_W + STOP_BITS;
  localparam int RW = $clog2(FRAME_W + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (line_oe) run_q <= (run_q == RW'(FRAME_W + 1)) ? run_q : run_q + 1'b1;
    else run_q <= '0;
  end

  p_idle_high_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    !line_oe |-> line_out);

  p_frame_max_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    run_q <= RW'(FRAME_W));

  p_frame_len_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    ($fell(line_oe) && enable && $past(enable)) |-> (run_q == RW'(FRAME_W)));

  p_busy_not_ready_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    line_oe |-> !tx_ready);

  p_hold_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) &&
                                 $stable(rx_parity_err) && $stable(rx_frame_err)));

  p_ignore_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    line_oe |=> !$rose(rx_valid));

  p_disabled_r10: assert property (@(posedge sclk) disable iff (!rst_n)
    !enable |-> !tx_ready);
endmodule

bind sfx_xcvr sfx_checker #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_chk (
  .sclk         (sclk),
  .rst_n        (rst_n),
  .enable       (enable),
  .line_out     (line_out),
  .line_oe      (line_oe),
  .tx_ready     (tx_ready),
  .rx_data      (rx_data),
  .rx_parity_err(rx_parity_err),
  .rx_frame_err (rx_frame_err),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready)
);

// File: tb/sfx_xcvr_test.sv
`timescale 1ns/1ps
module sfx_xcvr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       tx_allow = 1'b1;
  logic       line_in = 1'b1;
  logic       line_out, line_oe;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_parity_err, rx_frame_err, rx_valid;
  logic       rx_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sfx_xcvr uut (
    .sclk(clk), .rst_n(rst_n), .enable(enable), .tx_allow(tx_allow),
    .line_in(line_in), .line_out(line_out), .line_oe(line_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // drives one 12-bit frame, one bit per rising edge; returns right after stop 2 is sampled
  task automatic rx_frame(input logic [7:0] b, input bit flip_par, input bit low_s1, input bit low_s2);
    logic [11:0] v;
    v = {~low_s2, ~low_s1, (^b) ^ flip_par, b, 1'b0};
    for (int i = 0; i < 12; i++) begin
      line_in = v[i];
      tick();
    end
    line_in = 1'b1;
  endtask

  task automatic check_rx(input logic [7:0] b, input bit pe, input bit fe, input string req);
    check(rx_valid === 1'b1, req, rx_valid, 1);
    check(rx_data === b, req, rx_data, b);
    check(rx_parity_err === pe && rx_frame_err === fe, req,
          {rx_parity_err, rx_frame_err}, {pe, fe});
  endtask

  // offers a byte, checks every bit on the line, holds line_in low meanwhile
  task automatic tx_frame(input logic [7:0] b);
    logic [11:0] v;
    int bad_bit, bad_oe;
    v = {2'b11, ^b, b, 1'b0};
    bad_bit = 0;
    bad_oe = 0;
    tx_data = b;
    tx_valid = 1'b1;
    check(tx_ready === 1'b1, "R3 ready when idle", tx_ready, 1);
    line_in = 1'b0;
    tick();
    tx_valid = 1'b0;
    check(tx_ready === 1'b0, "R3 ready drops while sending", tx_ready, 0);
    for (int i = 0; i < 12; i++) begin
      if (line_out !== v[i]) bad_bit++;
      if (line_oe !== 1'b1) bad_oe++;
      if (i == 11) line_in = 1'b1;
      tick();
    end
    check(bad_bit == 0, "R1 frame bits", bad_bit, 0);
    check(bad_oe == 0, "R2 oe over frame", bad_oe, 0);
    check(line_oe === 1'b0 && line_out === 1'b1, "R2 release after frame",
          {line_oe, line_out}, 2'b01);
    check(rx_valid === 1'b0, "R9 no byte from own frame", rx_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(line_oe === 1'b0 && line_out === 1'b1 && rx_valid === 1'b0, "R11 reset state",
          {line_oe, line_out, rx_valid}, 3'b010);
    rst_n = 1'b1;
    tick();
    check(line_oe === 1'b0 && line_out === 1'b1 && rx_valid === 1'b0, "R11 after release",
          {line_oe, line_out, rx_valid}, 3'b010);

    // R4 / R8: every byte value, back to back with no idle gap
    for (int b = 0; b < 256; b++) begin
      rx_frame(8'(b), 0, 0, 0);
      check_rx(8'(b), 0, 0, "R4 R8 receive sweep");
    end
    tick();

    // R5 / R6: fault injection over a spread of bytes
    for (int b = 3; b < 256; b += 37) begin
      rx_frame(8'(b), 1, 0, 0);
      check_rx(8'(b), 1, 0, "R5 parity error");
      rx_frame(8'(b), 0, 1, 0);
      check_rx(8'(b), 0, 1, "R6 stop1 low");
      rx_frame(8'(b), 0, 0, 1);
      check_rx(8'(b), 0, 1, "R6 stop2 low");
    end
    tick();

    // R7: back-pressure, second frame discarded
    rx_ready = 1'b0;
    rx_frame(8'hA5, 0, 0, 0);
    check_rx(8'hA5, 0, 0, "R7 first byte");
    rx_frame(8'h3C, 1, 1, 0);
    check_rx(8'hA5, 0, 0, "R7 held under back-pressure");
    tick();
    check_rx(8'hA5, 0, 0, "R7 still held");
    rx_ready = 1'b1;
    tick();
    check(rx_valid === 1'b0, "R7 valid clears after accept", rx_valid, 0);

    // R1 / R2 / R9: every byte value transmitted
    for (int b = 0; b < 256; b++) tx_frame(8'(b));

    // R3: turnaround permit holds off transmission
    tx_allow = 1'b0;
    tx_data = 8'h81;
    tx_valid = 1'b1;
    repeat (4) tick();
    check(tx_ready === 1'b0 && line_oe === 1'b0, "R3 held by tx_allow", {tx_ready, line_oe}, 0);
    tx_valid = 1'b0;
    tx_allow = 1'b1;
    tick();

    // R3: receiver busy blocks transmission
    begin
      logic [11:0] v;
      int seen;
      v = {2'b11, ^8'h5A, 8'h5A, 1'b0};
      seen = 0;
      for (int i = 0; i < 12; i++) begin
        line_in = v[i];
        tick();
        if (i < 11 && tx_ready !== 1'b0) seen++;
      end
      line_in = 1'b1;
      check(seen == 0, "R3 not ready while receiving", seen, 0);
      check_rx(8'h5A, 0, 0, "R3 receive alongside");
      tick();
    end

    // R10: disabled port
    enable = 1'b0;
    line_in = 1'b0;
    repeat (15) tick();
    check(rx_valid === 1'b0 && tx_ready === 1'b0, "R10 disabled ignores line",
          {rx_valid, tx_ready}, 0);
    line_in = 1'b1;
    enable = 1'b1;
    tick();
    tick();
    check(rx_valid === 1'b0, "R10 no late byte", rx_valid, 0);

    // R10: disable mid-frame abandons the frame
    tx_data = 8'hF0;
    tx_valid = 1'b1;
    tick();
    tx_valid = 1'b0;
    repeat (3) tick();
    check(line_oe === 1'b1, "R10 frame underway", line_oe, 1);
    enable = 1'b0;
    tick();
    check(line_oe === 1'b0 && line_out === 1'b1, "R10 frame abandoned",
          {line_oe, line_out}, 2'b01);
    enable = 1'b1;
    tick();
    tx_frame(8'h6B);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule